// File: doc/BRIEF.md
# Tag-Wakeup Out-of-Order Scheduler Queue

This block is the scheduling buffer in front of one execution unit of an out-of-order core. A dispatch stage hands it renamed micro-ops in program order. Each op carries its physical destination register index and the physical indices of its source operands. The op waits in a free slot until every source is known to be produced. Producers announce completion by broadcasting their destination indices on several result-tag buses in the same cycle. Entries hold only these narrow indices and never capture operand values. The register file read and any bypassing happen downstream.

Each cycle the queue issues at most one op whose sources are all ready. It picks the oldest such op by insertion age, regardless of its slot position. The issuing slot is released at once for a newer op. A one-cycle release pulse goes back to dispatch so that dispatch can keep its free-entry accounting. When every slot is taken, the insert ready signal drops and the in-order front end must stall. A flush input empties the queue in one cycle.

Top module: `sched_queue`

## Requirements
- R1: An entry is offered for issue only when all of its source-ready bits are set, and at most one op issues per cycle. An op inserted at clock edge E with all sources ready appears on the issue output after edge E+1, with its payload and destination tag.
- R2: The slot of an issuing op becomes free in the same edge that registers the issue. After an issue from a full queue, insert ready is high again in the cycle where that issue is visible.
- R3: A source becomes ready when one of the four broadcast buses carries a matching 9-bit tag with its valid bit set. A matching tag on a bus whose valid bit is clear has no effect.
- R4: When several entries are ready in the same cycle, the one inserted earliest issues first, and the others follow in insertion order on later cycles.
- R5: A source whose tag is broadcast in the same cycle as its insertion is stored as ready, so no further broadcast is needed.
- R6: The queue holds 14 entries. With all 14 occupied, insert ready is low, and an insert presented while it is low is dropped.
- R7: Flush invalidates every entry in one cycle and suppresses issue in the following cycle. Later broadcasts of the flushed ops' tags issue nothing.
- R8: The release output is high for exactly the cycles in which the issue output is valid, one cycle per issued op.
- R9: After reset, insert ready is high, and both issue valid and release are low.
- R10: A younger op whose sources are ready issues ahead of an older op that is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty the queue |
| ins_valid_i | input | 1 | Dispatch presents an op |
| ins_ready_o | output | 1 | A free slot exists |
| ins_payload_i | input | PAY_W (16) | Opaque op control bits |
| ins_dst_i | input | TAG_W (9) | Physical destination index |
| ins_src_i | input | NUM_SRC*TAG_W (18) | Source indices, source 0 in the low bits |
| ins_src_rdy_i | input | NUM_SRC (2) | Sources already produced at rename |
| bc_valid_i | input | NUM_BC (4) | Per-bus broadcast valid |
| bc_tag_i | input | NUM_BC*TAG_W (36) | Broadcast indices, bus 0 in the low bits |
| iss_valid_o | output | 1 | An op is issued this cycle |
| iss_payload_o | output | PAY_W (16) | Payload of the issued op |
| iss_dst_o | output | TAG_W (9) | Destination index of the issued op |
| release_o | output | 1 | One-cycle slot-release pulse to dispatch |

## Verification
The assertions assume that dispatch only raises insert valid with stable fields for that cycle. They also assume that a tag is broadcast once per producer, and that no source of a queued op names a tag that was already broadcast and not re-allocated. The stimulus respects these assumptions: every test uses fresh tags, broadcasts each tag for a single cycle, and drives all inputs on the falling edge. Ordering cases are built so that the issue order follows from R4 and R10 alone. A scoreboard compares each issued payload and destination pair against the expected sequence.

// File: rtl/sched_q_pkg.sv
package sched_q_pkg;

   localparam int unsigned DEF_DEPTH   = 14;
   localparam int unsigned DEF_TAG_W   = 9;
   localparam int unsigned DEF_NUM_BC  = 4;
   localparam int unsigned DEF_NUM_SRC = 2;
   localparam int unsigned DEF_PAY_W   = 16;

   // count of set bits, used for occupancy checks
   function automatic int unsigned pop_count(input logic [63:0] v, input int unsigned n);
      int unsigned c;
      c = 0;
      for (int unsigned i = 0; i < n; i++) begin
         c += int'(v[i]);
      end
      return c;
   endfunction

endpackage

// File: rtl/sched_wakeup.sv
module sched_wakeup #(
   parameter int unsigned TAG_W   = sched_q_pkg::DEF_TAG_W,
   parameter int unsigned NUM_BC  = sched_q_pkg::DEF_NUM_BC,
   parameter int unsigned NUM_SRC = sched_q_pkg::DEF_NUM_SRC
) (
   input  logic [NUM_SRC*TAG_W-1:0] src_tags,
   input  logic [NUM_BC-1:0]        bc_valid,
   input  logic [NUM_BC*TAG_W-1:0]  bc_tags,
   output logic [NUM_SRC-1:0]       hit
);

   logic [NUM_BC-1:0] eq [NUM_SRC];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      for (genvar b = 0; b < NUM_BC; b++) begin : g_bus
         assign eq[s][b] = bc_valid[b] &&
                           (bc_tags[b*TAG_W +: TAG_W] == src_tags[s*TAG_W +: TAG_W]);
      end
      assign hit[s] = |eq[s];
   end

endmodule

// File: rtl/sched_slot_alloc.sv
module sched_slot_alloc #(
   parameter int unsigned DEPTH = sched_q_pkg::DEF_DEPTH
) (
   input  logic [DEPTH-1:0] vld,
   output logic [DEPTH-1:0] free_oh,
   output logic             has_free
);

   always_comb begin
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int unsigned i = 0; i < DEPTH; i++) begin
         if (!vld[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   assign has_free = ~&vld;

endmodule

// File: rtl/sched_age_pick.sv
module sched_age_pick #(
   parameter int unsigned DEPTH = sched_q_pkg::DEF_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] vld,
   input  logic [DEPTH-1:0] ins_oh,
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] grant,
   output logic             any_grant
);

   // older_q[i][j] set: slot i was inserted before slot j
   logic [DEPTH-1:0] older_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int unsigned i = 0; i < DEPTH; i++) begin
            older_q[i] <= '0;
         end
      end else begin
         for (int unsigned i = 0; i < DEPTH; i++) begin
            for (int unsigned j = 0; j < DEPTH; j++) begin
               if (ins_oh[i]) begin
                  older_q[i][j] <= 1'b0;
               end else if (ins_oh[j]) begin
                  older_q[i][j] <= vld[i];
               end
            end
         end
      end
   end

   always_comb begin
      for (int unsigned i = 0; i < DEPTH; i++) begin
         logic [DEPTH-1:0] col;
         for (int unsigned j = 0; j < DEPTH; j++) begin
            col[j] = older_q[j][i];
         end
         grant[i] = req[i] && !(|(req & col));
      end
   end

   assign any_grant = |grant;

   a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r1_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      any_grant |-> |req);

endmodule

// File: rtl/sched_queue.sv
module sched_queue #(
   parameter int unsigned DEPTH   = sched_q_pkg::DEF_DEPTH,
   parameter int unsigned TAG_W   = sched_q_pkg::DEF_TAG_W,
   parameter int unsigned NUM_BC  = sched_q_pkg::DEF_NUM_BC,
   parameter int unsigned NUM_SRC = sched_q_pkg::DEF_NUM_SRC,
   parameter int unsigned PAY_W   = sched_q_pkg::DEF_PAY_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush_i,
   input  logic                     ins_valid_i,
   output logic                     ins_ready_o,
   input  logic [PAY_W-1:0]         ins_payload_i,
   input  logic [TAG_W-1:0]         ins_dst_i,
   input  logic [NUM_SRC*TAG_W-1:0] ins_src_i,
   input  logic [NUM_SRC-1:0]       ins_src_rdy_i,
   input  logic [NUM_BC-1:0]        bc_valid_i,
   input  logic [NUM_BC*TAG_W-1:0]  bc_tag_i,
   output logic                     iss_valid_o,
   output logic [PAY_W-1:0]         iss_payload_o,
   output logic [TAG_W-1:0]         iss_dst_o,
   output logic                     release_o
);

   localparam int unsigned SRC_BITS = NUM_SRC * TAG_W;

   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("sched_queue: DEPTH must lie in 2..64");
   end
   if (NUM_SRC < 1 || NUM_BC < 1 || TAG_W < 1 || PAY_W < 1) begin : g_bad_width
      $error("sched_queue: widths and counts must be nonzero");
   end

   logic [DEPTH-1:0]    vld_q;
   logic [PAY_W-1:0]    pay_q [DEPTH];
   logic [TAG_W-1:0]    dst_q [DEPTH];
   logic [SRC_BITS-1:0] src_q [DEPTH];
   logic [NUM_SRC-1:0]  rdy_q [DEPTH];
   logic [NUM_SRC-1:0]  hit_w [DEPTH];

   logic [NUM_SRC-1:0]  ins_hit;
   logic [DEPTH-1:0]    free_oh, ins_oh, req, grant;
   logic                has_free, any_grant, ins_fire;

   // per-entry tag comparators
   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      sched_wakeup #(.TAG_W(TAG_W), .NUM_BC(NUM_BC), .NUM_SRC(NUM_SRC)) u_wake (
         .src_tags (src_q[e]),
         .bc_valid (bc_valid_i),
         .bc_tags  (bc_tag_i),
         .hit      (hit_w[e])
      );
      assign req[e] = vld_q[e] && (&rdy_q[e]);
   end

   // comparator on the insert path for same-cycle capture
   sched_wakeup #(.TAG_W(TAG_W), .NUM_BC(NUM_BC), .NUM_SRC(NUM_SRC)) u_ins_wake (
      .src_tags (ins_src_i),
      .bc_valid (bc_valid_i),
      .bc_tags  (bc_tag_i),
      .hit      (ins_hit)
   );

   sched_slot_alloc #(.DEPTH(DEPTH)) u_alloc (
      .vld      (vld_q),
      .free_oh  (free_oh),
      .has_free (has_free)
   );

   assign ins_ready_o = has_free;
   assign ins_fire    = ins_valid_i && has_free && !flush_i;
   assign ins_oh      = ins_fire ? free_oh : '0;

   sched_age_pick #(.DEPTH(DEPTH)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld       (vld_q),
      .ins_oh    (ins_oh),
      .req       (req),
      .grant     (grant),
      .any_grant (any_grant)
   );

   // entry storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int unsigned e = 0; e < DEPTH; e++) begin
            pay_q[e] <= '0;
            dst_q[e] <= '0;
            src_q[e] <= '0;
            rdy_q[e] <= '0;
         end
      end else if (flush_i) begin
         vld_q <= '0;
      end else begin
         for (int unsigned e = 0; e < DEPTH; e++) begin
            if (ins_oh[e]) begin
               vld_q[e] <= 1'b1;
               pay_q[e] <= ins_payload_i;
               dst_q[e] <= ins_dst_i;
               src_q[e] <= ins_src_i;
               rdy_q[e] <= ins_src_rdy_i | ins_hit;
            end else begin
               if (grant[e]) begin
                  vld_q[e] <= 1'b0;
               end
               if (vld_q[e]) begin
                  rdy_q[e] <= rdy_q[e] | hit_w[e];
               end
            end
         end
      end
   end

   // issue selection mux
   logic [PAY_W-1:0] sel_pay;
   logic [TAG_W-1:0] sel_dst;
   always_comb begin
      sel_pay = '0;
      sel_dst = '0;
      for (int unsigned e = 0; e < DEPTH; e++) begin
         if (grant[e]) begin
            sel_pay = sel_pay | pay_q[e];
            sel_dst = sel_dst | dst_q[e];
         end
      end
   end

   // registered issue stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iss_valid_o   <= 1'b0;
         iss_payload_o <= '0;
         iss_dst_o     <= '0;
      end else begin
         iss_valid_o <= any_grant && !flush_i;
         if (any_grant) begin
            iss_payload_o <= sel_pay;
            iss_dst_o     <= sel_dst;
         end
      end
   end

   // release pulse toward dispatch
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         release_o <= 1'b0;
      end else begin
         release_o <= |(grant & vld_q) && !flush_i;
      end
   end

   a_r6_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_ready_o |-> (&vld_q));

   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (vld_q == '0) && !iss_valid_o);

   a_r8_release_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
      release_o == iss_valid_o);

   for (genvar e = 0; e < DEPTH; e++) begin : g_chk
      a_r2_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
         grant[e] |=> !vld_q[e]);
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk_src
         a_r3_wake_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q[e] && hit_w[e][s] && !flush_i && !grant[e]) |=> rdy_q[e][s]);
      end
   end

endmodule

// File: tb/sched_queue_tb_top.sv
module sched_queue_tb_top;

   localparam int DEPTH = 14;
   localparam int TW    = 9;
   localparam int PW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          ins_valid = 1'b0;
   logic          ins_ready;
   logic [PW-1:0] ins_payload = '0;
   logic [TW-1:0] ins_dst = '0;
   logic [2*TW-1:0] ins_src = '0;
   logic [1:0]    ins_src_rdy = '0;
   logic [3:0]    bc_valid = '0;
   logic [4*TW-1:0] bc_tag = '0;
   logic          iss_valid;
   logic [PW-1:0] iss_payload;
   logic [TW-1:0] iss_dst;
   logic          release_p;

   int tests = 0;
   int fails = 0;
   logic [TW+PW-1:0] exp_q [$];

   always #2 clk = ~clk;

   sched_queue dut_i (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .ins_valid_i(ins_valid), .ins_ready_o(ins_ready),
      .ins_payload_i(ins_payload), .ins_dst_i(ins_dst),
      .ins_src_i(ins_src), .ins_src_rdy_i(ins_src_rdy),
      .bc_valid_i(bc_valid), .bc_tag_i(bc_tag),
      .iss_valid_o(iss_valid), .iss_payload_o(iss_payload),
      .iss_dst_o(iss_dst), .release_o(release_p)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // driver: insert one op over one clock edge
   task automatic put(input logic [PW-1:0] p, input logic [TW-1:0] d,
                      input logic [TW-1:0] s0, input logic [TW-1:0] s1, input logic [1:0] r);
      ins_valid = 1'b1; ins_payload = p; ins_dst = d;
      ins_src = {s1, s0}; ins_src_rdy = r;
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic expect_issue(input logic [PW-1:0] p, input logic [TW-1:0] d);
      exp_q.push_back({d, p});
   endtask

   task automatic bcast(input int bus, input logic [TW-1:0] t, input bit v);
      bc_valid = '0;
      bc_valid[bus] = v;
      bc_tag[bus*TW +: TW] = t;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (release_p !== iss_valid)
            check(1'b0, "R8 release", {31'd0, release_p}, {31'd0, iss_valid});
         if (iss_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1/R6/R7 unexpected issue", {7'd0, iss_dst, iss_payload}, 32'd0);
            end else begin
               logic [TW+PW-1:0] e;
               e = exp_q.pop_front();
               check({iss_dst, iss_payload} == e, "R1/R4 issue order",
                     {7'd0, iss_dst, iss_payload}, {7'd0, e});
            end
         end
      end
   end

   initial begin
      #400000;
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(ins_ready === 1'b1, "R9 ready", {31'd0, ins_ready}, 1);
      check(iss_valid === 1'b0, "R9 issue", {31'd0, iss_valid}, 0);
      check(release_p === 1'b0, "R9 release", {31'd0, release_p}, 0);

      // R1 basic latency
      expect_issue(16'hA001, 9'd100);
      put(16'hA001, 9'd100, 9'd1, 9'd2, 2'b11);
      check(iss_valid === 1'b0, "R1 not early", {31'd0, iss_valid}, 0);
      @(negedge clk);
      check(iss_valid === 1'b1, "R1 latency", {31'd0, iss_valid}, 1);
      idle(2);

      // R10 younger ready passes older waiting; R3 wake on bus 3
      put(16'hB002, 9'd101, 9'd5, 9'd2, 2'b10);
      expect_issue(16'hC003, 9'd102);
      put(16'hC003, 9'd102, 9'd3, 9'd4, 2'b11);
      idle(3);
      check(exp_q.size() == 0, "R10 younger issued", exp_q.size(), 0);
      // R3: matching tag on a bus with valid low has no effect
      bcast(1, 9'd5, 1'b0);
      idle(1);
      bc_valid = '0;
      idle(3);
      check(iss_valid === 1'b0, "R3 invalid bus ignored", {31'd0, iss_valid}, 0);
      expect_issue(16'hB002, 9'd101);
      bcast(3, 9'd5, 1'b1);
      idle(1);
      bc_valid = '0;
      idle(3);
      check(exp_q.size() == 0, "R3 woken", exp_q.size(), 0);

      // R4 oldest first with a shared wake tag
      for (int i = 0; i < 3; i++) begin
         put(16'hD000 + PW'(i), 9'd110 + TW'(i), 9'd7, 9'd0, 2'b10);
         expect_issue(16'hD000 + PW'(i), 9'd110 + TW'(i));
      end
      bcast(0, 9'd7, 1'b1);
      idle(1);
      bc_valid = '0;
      idle(5);
      check(exp_q.size() == 0, "R4 all issued", exp_q.size(), 0);

      // R5 same-cycle capture, two sources woken by two buses
      bc_valid = 4'b0110;
      bc_tag[1*TW +: TW] = 9'd9;
      bc_tag[2*TW +: TW] = 9'd8;
      expect_issue(16'hE005, 9'd120);
      put(16'hE005, 9'd120, 9'd9, 9'd8, 2'b00);
      bc_valid = '0;
      idle(4);
      check(exp_q.size() == 0, "R5 captured", exp_q.size(), 0);

      // partial readiness: only one of two sources woken
      put(16'hF006, 9'd121, 9'd30, 9'd31, 2'b00);
      bcast(2, 9'd30, 1'b1); idle(1); bc_valid = '0;
      idle(3);
      check(iss_valid === 1'b0, "R1 half ready held", {31'd0, iss_valid}, 0);
      expect_issue(16'hF006, 9'd121);
      bcast(0, 9'd31, 1'b1); idle(1); bc_valid = '0;
      idle(3);
      check(exp_q.size() == 0, "R1 fully ready issued", exp_q.size(), 0);

      // R6 capacity and stall, R2 slot freed
      for (int i = 0; i < DEPTH; i++) begin
         check(ins_ready === 1'b1, "R6 room before full", {31'd0, ins_ready}, 1);
         put(16'h1000 + PW'(i), TW'(i) + 9'd200, 9'd20, 9'd0, 2'b10);
      end
      check(ins_ready === 1'b0, "R6 full stall", {31'd0, ins_ready}, 0);
      ins_valid = 1'b1; ins_payload = 16'hDEAD; ins_dst = 9'd77;
      ins_src = '0; ins_src_rdy = 2'b11;
      idle(2);
      ins_valid = 1'b0;
      check(ins_ready === 1'b0, "R6 still full", {31'd0, ins_ready}, 0);
      for (int i = 0; i < DEPTH; i++) expect_issue(16'h1000 + PW'(i), TW'(i) + 9'd200);
      bcast(3, 9'd20, 1'b1); idle(1); bc_valid = '0;
      idle(1);
      check(ins_ready === 1'b1, "R2 slot freed on issue", {31'd0, ins_ready}, 1);
      idle(DEPTH + 3);
      check(exp_q.size() == 0, "R6 exactly 14 drained", exp_q.size(), 0);

      // R7 flush
      put(16'h7001, 9'd140, 9'd40, 9'd0, 2'b10);
      put(16'h7002, 9'd141, 9'd40, 9'd0, 2'b10);
      flush = 1'b1; idle(1); flush = 1'b0;
      bcast(0, 9'd40, 1'b1); idle(1); bc_valid = '0;
      idle(4);
      check(iss_valid === 1'b0, "R7 flushed no issue", {31'd0, iss_valid}, 0);
      check(ins_ready === 1'b1, "R7 empty after flush", {31'd0, ins_ready}, 1);
      // ready op flushed before it can issue
      put(16'h7003, 9'd142, 9'd0, 9'd0, 2'b11);
      flush = 1'b1; idle(1); flush = 1'b0;
      idle(3);
      check(exp_q.size() == 0, "R7 nothing pending", exp_q.size(), 0);

      idle(2);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule